// File: doc/BRIEF.md
# Converter Coarse Time Base with Pulse-Per-Second Phase Capture

This block keeps the coarse time reference for a fine time-to-digital converter whose start events occur every 256 ns. It runs on an 8 ns reference clock and has three counters. A 5-bit subcycle counter steps through the reference ticks of one start period. A coarse counter counts start periods. A seconds counter advances once one second's worth of start periods has elapsed.

An external pulse-per-second strobe can arrive on any reference tick. The block does not realign the start generator to it. Instead it records the phase difference, modulo 32, between the external coarse counter's low bits and the local subcycle counter. Downstream postprocessing adds that offset to each timestamp.

On every input event the block latches a snapshot of all three counters together with the current offset. It then raises a valid strobe for one cycle, so the snapshot can be merged with the converter's fine value.

Top module: `tdc_timebase`

## Requirements
- R1: While reset is asserted and after its release, the snapshot outputs are all zero and the valid strobe is low until the first event.
- R2: The subcycle counter advances by one every reference cycle, from 0 up to 2^SUB_W-1 (31 by default) and back to 0. `start_o` is high exactly in the cycle in which the counter holds its top value.
- R3: The coarse counter advances by one in each cycle in which `start_o` is high, and holds its value in all other cycles.
- R4: When the coarse counter is at CYC_PER_SEC-1 in a cycle with `start_o` high, the coarse counter returns to 0 and the seconds counter advances by one.
- R5: In a cycle with `pps_i` high, the stored offset becomes (`ext_lo_i` minus the current subcycle value) modulo 2^SUB_W.
- R6: `pps_i` never resets or shifts the subcycle, coarse or seconds counters.
- R7: In a cycle with `event_i` high, the counter values of that cycle are captured. In the following cycle `snap_valid_o` is high for exactly one cycle and the snapshot outputs carry the captured values.
- R8: Without an event, `snap_valid_o` is low and the snapshot outputs keep their last value.
- R9: When `pps_i` and `event_i` are high in the same cycle, the snapshot carries the offset computed in that cycle.
- R10: `ext_lo_i` has no effect on the stored offset in cycles without `pps_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 8 ns reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Pulse-per-second strobe, one cycle |
| ext_lo_i | input | SUB_W | Low bits of the external coarse counter |
| event_i | input | 1 | Input event strobe, one cycle |
| start_o | output | 1 | High in the last reference cycle of each start period |
| snap_valid_o | output | 1 | Snapshot valid, one cycle after an event |
| snap_sec_o | output | SEC_W | Captured seconds count |
| snap_coarse_o | output | CW | Captured coarse count |
| snap_sub_o | output | SUB_W | Captured subcycle count |
| snap_offset_o | output | SUB_W | Captured phase offset |

## Verification
Two functions can fall in the same cycle. The first is offset capture on a pulse-per-second strobe coinciding with an event. The second is an event landing in the last subcycle of the last coarse period of a second, so the snapshot competes with the rollover. The bench drives `pps_i` and `event_i` together on one falling edge with a chosen `ext_lo_i`, and expects the new offset in the snapshot. It also places an event at the tick where the subcycle is 31 and the coarse count is at its limit. There it expects the pre-rollover values, followed one period later by the advanced second.

// File: rtl/tdc_timebase_pkg.sv
package tdc_timebase_pkg;
  localparam int unsigned DEF_SUB_W        = 5;        // 32 ticks of 8 ns per start period
  localparam int unsigned DEF_CYC_PER_SEC  = 3906250;  // 1 s / 256 ns
  localparam int unsigned DEF_SEC_W        = 32;
endpackage

// File: rtl/tb_subcycle_ctr.sv
module tb_subcycle_ctr #(
  parameter int unsigned SUB_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SUB_W-1:0] sub_o,
  output logic             start_o
);
  localparam logic [SUB_W-1:0] SubMax = {SUB_W{1'b1}};

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sub_q <= '0;
    else         sub_q <= sub_q + SUB_W'(1);
  end

  assign sub_o   = sub_q;
  assign start_o = (sub_q == SubMax);

  assert_sub_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q != SubMax) |=> (sub_q == $past(sub_q) + SUB_W'(1)));
  assert_sub_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (sub_q == '0));
endmodule

// File: rtl/tb_coarse_sec.sv
module tb_coarse_sec #(
  parameter int unsigned CYC_PER_SEC = 3906250,
  parameter int unsigned SEC_W       = 32,
  localparam int unsigned CW         = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CW-1:0]    coarse_o,
  output logic [SEC_W-1:0] sec_o
);
  localparam logic [CW-1:0] CoarseLast = CW'(CYC_PER_SEC - 1);

  logic [CW-1:0]    coarse_q;
  logic [SEC_W-1:0] sec_q;
  logic             last_c;

  assign last_c = (coarse_q == CoarseLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      sec_q    <= '0;
    end else if (start_i) begin
      if (last_c) begin
        coarse_q <= '0;
        sec_q    <= sec_q + SEC_W'(1);
      end else begin
        coarse_q <= coarse_q + CW'(1);
      end
    end
  end

  assign coarse_o = coarse_q;
  assign sec_o    = sec_q;

  assert_coarse_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !last_c) |=> (coarse_q == $past(coarse_q) + CW'(1)) && $stable(sec_q));
  assert_coarse_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(coarse_q) && $stable(sec_q));
  assert_sec_roll_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && last_c) |=> (coarse_q == '0) && (sec_q == $past(sec_q) + SEC_W'(1)));
endmodule

// File: rtl/tb_pps_offset.sv
module tb_pps_offset #(
  parameter int unsigned SUB_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic [SUB_W-1:0] ext_lo_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic [SUB_W-1:0] offset_o,
  output logic [SUB_W-1:0] offset_fwd_o
);
  logic [SUB_W-1:0] offset_q;
  logic [SUB_W-1:0] diff_c;

  // modulo 2^SUB_W by width truncation
  assign diff_c = ext_lo_i - sub_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    offset_q <= '0;
    else if (pps_i) offset_q <= diff_c;
  end

  assign offset_o     = offset_q;
  assign offset_fwd_o = pps_i ? diff_c : offset_q;

  assert_offset_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pps_i |=> $stable(offset_q));
  assert_offset_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_i |=> (offset_q + $past(sub_i) == $past(ext_lo_i)));
endmodule

// File: rtl/tb_snapshot.sv
module tb_snapshot #(
  parameter int unsigned SUB_W = 5,
  parameter int unsigned CW    = 22,
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [CW-1:0]    coarse_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SUB_W-1:0] offset_i,
  output logic             valid_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [CW-1:0]    coarse_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [SUB_W-1:0] offset_o
);
  logic             valid_q;
  logic [SEC_W-1:0] sec_q;
  logic [CW-1:0]    coarse_q;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q    <= '0;
      coarse_q <= '0;
      sub_q    <= '0;
      offset_q <= '0;
    end else if (event_i) begin
      sec_q    <= sec_i;
      coarse_q <= coarse_i;
      sub_q    <= sub_i;
      offset_q <= offset_i;
    end
  end

  assign valid_o  = valid_q;
  assign sec_o    = sec_q;
  assign coarse_o = coarse_q;
  assign sub_o    = sub_q;
  assign offset_o = offset_q;

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> valid_q && (sub_q == $past(sub_i)));
  assert_snap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> !valid_q && $stable(sec_q) && $stable(coarse_q) && $stable(sub_q) && $stable(offset_q));
endmodule

// File: rtl/tdc_timebase.sv
module tdc_timebase
  import tdc_timebase_pkg::*;
#(
  parameter int unsigned SUB_W       = DEF_SUB_W,
  parameter int unsigned CYC_PER_SEC = DEF_CYC_PER_SEC,
  parameter int unsigned SEC_W       = DEF_SEC_W,
  localparam int unsigned CW         = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic [SUB_W-1:0] ext_lo_i,
  input  logic             event_i,
  output logic             start_o,
  output logic             snap_valid_o,
  output logic [SEC_W-1:0] snap_sec_o,
  output logic [CW-1:0]    snap_coarse_o,
  output logic [SUB_W-1:0] snap_sub_o,
  output logic [SUB_W-1:0] snap_offset_o
);
  logic [SUB_W-1:0] sub;
  logic             start;
  logic [CW-1:0]    coarse;
  logic [SEC_W-1:0] sec;
  logic [SUB_W-1:0] offset;
  logic [SUB_W-1:0] offset_fwd;

  tb_subcycle_ctr #(.SUB_W(SUB_W)) u_sub (
    .clk_i, .rst_ni, .sub_o(sub), .start_o(start)
  );

  tb_coarse_sec #(.CYC_PER_SEC(CYC_PER_SEC), .SEC_W(SEC_W)) u_coarse (
    .clk_i, .rst_ni, .start_i(start), .coarse_o(coarse), .sec_o(sec)
  );

  tb_pps_offset #(.SUB_W(SUB_W)) u_off (
    .clk_i, .rst_ni, .pps_i, .ext_lo_i, .sub_i(sub),
    .offset_o(offset), .offset_fwd_o(offset_fwd)
  );

  tb_snapshot #(.SUB_W(SUB_W), .CW(CW), .SEC_W(SEC_W)) u_snap (
    .clk_i, .rst_ni, .event_i,
    .sec_i(sec), .coarse_i(coarse), .sub_i(sub), .offset_i(offset_fwd),
    .valid_o(snap_valid_o), .sec_o(snap_sec_o), .coarse_o(snap_coarse_o),
    .sub_o(snap_sub_o), .offset_o(snap_offset_o)
  );

  assign start_o = start;

  // pps never disturbs the local phase
  assert_pps_no_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_i |=> (sub == $past(sub) + SUB_W'(1)));
  assert_coincide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pps_i && event_i) |=> (snap_offset_o == offset));
endmodule

// File: tb/tb_tdc_timebase.sv
module tb_tdc_timebase;
  localparam int unsigned SUB_W = 5;
  localparam int unsigned CPS   = 5;
  localparam int unsigned SEC_W = 16;
  localparam int unsigned CW    = $clog2(CPS);
  localparam int unsigned NSUB  = 1 << SUB_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pps_i = 1'b0;
  logic [SUB_W-1:0] ext_lo_i = '0;
  logic             event_i = 1'b0;
  logic             start_o, snap_valid_o;
  logic [SEC_W-1:0] snap_sec_o;
  logic [CW-1:0]    snap_coarse_o;
  logic [SUB_W-1:0] snap_sub_o, snap_offset_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [SUB_W-1:0] exp_off = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  tdc_timebase #(.SUB_W(SUB_W), .CYC_PER_SEC(CPS), .SEC_W(SEC_W)) dut (
    .clk_i(clk), .rst_ni, .pps_i, .ext_lo_i, .event_i, .start_o, .snap_valid_o,
    .snap_sec_o, .snap_coarse_o, .snap_sub_o, .snap_offset_o
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // fire one event in the current cycle, optionally with pps, and check the snapshot
  task automatic fire(input string req, input bit with_pps, input logic [SUB_W-1:0] ext);
    int c = cyc;
    int per = c / NSUB;
    logic [SUB_W-1:0] sub_now = SUB_W'(c % NSUB);
    event_i = 1'b1;
    if (with_pps) begin
      pps_i = 1'b1;
      ext_lo_i = ext;
      exp_off = ext - sub_now;
    end
    tick();
    event_i = 1'b0;
    pps_i = 1'b0;
    chk({req, " valid"}, snap_valid_o, 1);
    chk({req, " sub"}, snap_sub_o, c % NSUB);
    chk({req, " coarse"}, snap_coarse_o, per % CPS);
    chk({req, " sec"}, snap_sec_o, per / CPS);
    chk({req, " offset"}, snap_offset_o, exp_off);
  endtask

  task automatic t_reset();
    chk("R1 valid", snap_valid_o, 0);
    chk("R1 sec", snap_sec_o, 0);
    chk("R1 coarse", snap_coarse_o, 0);
    chk("R1 sub", snap_sub_o, 0);
    chk("R1 offset", snap_offset_o, 0);
  endtask

  task automatic t_start();
    for (int i = 0; i < 70; i++) begin
      if (start_o != ((cyc % NSUB) == NSUB - 1)) chk("R2 start_o", start_o, !start_o);
      tick();
    end
    chk("R2 start_o pattern", 1, 1);
  endtask

  task automatic t_events();
    fire("R7 first", 0, '0);
    repeat (3) tick();
    fire("R3 later", 0, '0);
    fire("R7 back-to-back", 0, '0);
    repeat (17) tick();
    fire("R2 mid", 0, '0);
  endtask

  task automatic t_hold();
    logic [SUB_W-1:0] s = snap_sub_o;
    repeat (5) tick();
    chk("R8 valid low", snap_valid_o, 0);
    chk("R8 sub held", snap_sub_o, s);
  endtask

  task automatic t_pps();
    pps_i = 1'b1;
    ext_lo_i = 5'd3;
    exp_off = 5'd3 - SUB_W'(cyc % NSUB);
    tick();
    pps_i = 1'b0;
    repeat (9) tick();
    fire("R5 offset", 0, '0);
    fire("R6 counters after pps", 0, '0);
  endtask

  task automatic t_ext_ignored();
    for (int i = 0; i < 8; i++) begin
      ext_lo_i = SUB_W'(i * 7 + 1);
      tick();
    end
    fire("R10 ext ignored", 0, '0);
  endtask

  task automatic t_coincide();
    repeat (4) tick();
    fire("R9 coincide", 1, 5'd30);
    fire("R9 after", 0, '0);
  endtask

  task automatic t_rollover();
    while (!(((cyc % NSUB) == NSUB - 1) && ((cyc / NSUB) % CPS == CPS - 1))) tick();
    fire("R4 last tick", 0, '0);
    fire("R4 new second", 0, '0);
    chk("R4 coarse cleared", snap_coarse_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_start();
    t_events();
    t_hold();
    t_pps();
    t_ext_ignored();
    t_coincide();
    t_rollover();
    t_rollover();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule